// File: doc/BRIEF.md
# Single-Wire Slave Bit Layer

This block is the slave-side bit layer for a one-line open-drain bus that idles high and runs at two speeds, standard and overdrive. It resynchronizes the bus line into the clock domain, then times each low period against a one-microsecond tick supplied by the chip. From the length of each low period it tells apart master write slots, which it hands upward as single bits, and reset pulses, which it answers with a presence pulse of its own.

When the layer above has a bit to send, it raises `tx_valid` with the bit on `tx_bit`. The next slot the master opens then becomes a read slot: the block acknowledges with a one-cycle `tx_ack` and, for a zero, holds the line low past the master's sample point. The layer above enters overdrive through `od_enter`. A long reset returns the block to standard speed, while a short reset sent in overdrive keeps overdrive. After every rising edge a hold-off window masks falling glitches, so ringing on the line is not taken as a new slot.

Top module: `sw_slave_phy`

## Requirements
- R1: After reset, `pull_low_out` is 0, `od_active` is 0, and neither `rx_valid` nor `reset_detected` has pulsed.
- R2: At standard speed, a low period shorter than 30 us gives one `rx_valid` pulse with `rx_bit`=1 when the line rises. A low period of at least 30 us and under 480 us gives one pulse with `rx_bit`=0.
- R3: In overdrive, a low period shorter than 3 us gives `rx_bit`=1. A low period of at least 3 us and under 60 us gives `rx_bit`=0. Each gives exactly one `rx_valid` pulse.
- R4: A low period of 480 us or more, at either speed, gives one `reset_detected` pulse when the line rises and clears `od_active` to 0.
- R5: In overdrive, a low period of 60 to 80 us gives one `reset_detected` pulse and leaves `od_active` at 1.
- R6: In overdrive, a low period longer than 80 us and shorter than 480 us produces neither `rx_valid` nor `reset_detected`.
- R7: After a reset at standard speed, the block waits 30 us from the line's rise and then drives `pull_low_out` high for 120 us.
- R8: After a reset that leaves overdrive set, the presence wait is 3 us and the presence low lasts 12 us.
- R9: If `tx_valid` is high when a slot starts, `tx_ack` pulses once and no `rx_valid` follows. A 0 is sent by holding the line low until 30 us (standard) or 3 us (overdrive) after the slot start. A 1 is sent by not pulling the line at all.
- R10: For 4 us after any rising edge of the synchronized line, a low on the line does not start a slot. A low still present when this window ends starts a slot at that moment.
- R11: A one-cycle pulse on `od_enter` sets `od_active` to 1 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_us | input | 1 | One-cycle strobe once per microsecond |
| line_in | input | 1 | Bus line level, asynchronous |
| od_enter | input | 1 | Pulse: switch to overdrive speed |
| tx_valid | input | 1 | A bit is waiting for the next read slot |
| tx_bit | input | 1 | Bit to send in that read slot |
| pull_low_out | output | 1 | 1 = drive the open-drain line low |
| reset_detected | output | 1 | One-cycle pulse at the end of a reset pulse |
| rx_valid | output | 1 | One-cycle pulse: `rx_bit` holds a received write bit |
| rx_bit | output | 1 | Decoded write bit |
| tx_ack | output | 1 | One-cycle pulse: the pending bit was taken at slot start |
| od_active | output | 1 | 1 = overdrive timing in force |

## Verification
A wrong speed flag shows at once in the next slot's decode, and in the presence pulse after the next reset, whose timing is off by a factor of ten. A duration counter that is stuck or misclassifies shows as a wrong `rx_bit`, or as a reset missed or invented, when the line rises at the end of that very slot. A hold-off that is lost or stuck is caught within a few microseconds of a rising edge, either as a phantom bit from a glitch or as a bit lost from a deep droop. A read slot that drives wrongly is seen on the line at the master's sample point of that same slot.

// File: rtl/sw_phy_pkg.sv
package sw_phy_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_PDH,
    ST_PDL
  } slot_state_e;

  typedef enum logic [1:0] {
    CL_BIT0,
    CL_BIT1,
    CL_RESET,
    CL_NONE
  } low_class_e;

endpackage

// File: rtl/sw_line_sync.sv
module sw_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s,
  output logic rise
);

  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;

  // bus idles high, so the chain resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[SH_W-2:0], line_in};
  end

  assign line_s = sh_q[SYNC_STAGES-1];
  assign rise   = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

endmodule

// File: rtl/sw_holdoff.sv
module sw_holdoff #(
  parameter int HOLDOFF_US = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic load,
  output logic busy
);

  localparam int HO_W = $clog2(HOLDOFF_US + 1);
  localparam logic [HO_W-1:0] HO_LOAD = HO_W'(HOLDOFF_US);

  logic [HO_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  assign cnt_en = load | (tick & (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = HO_LOAD;
    else if (tick) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/sw_low_classify.sv
module sw_low_classify
  import sw_phy_pkg::*;
#(
  parameter int CNT_W         = 9,
  parameter int RST_STD_US    = 480,
  parameter int RST_OD_MIN_US = 60,
  parameter int RST_OD_MAX_US = 80,
  parameter int SAMPLE_STD_US = 30,
  parameter int SAMPLE_OD_US  = 3
) (
  input  logic [CNT_W-1:0] low_us,
  input  logic             od,
  output low_class_e       cls,
  output logic             clear_od
);

  localparam logic [CNT_W-1:0] L_RST    = CNT_W'(RST_STD_US);
  localparam logic [CNT_W-1:0] L_OD_MIN = CNT_W'(RST_OD_MIN_US);
  localparam logic [CNT_W-1:0] L_OD_MAX = CNT_W'(RST_OD_MAX_US);
  localparam logic [CNT_W-1:0] L_S_STD  = CNT_W'(SAMPLE_STD_US);
  localparam logic [CNT_W-1:0] L_S_OD   = CNT_W'(SAMPLE_OD_US);

  logic [CNT_W-1:0] sample_lim;

  assign sample_lim = od ? L_S_OD : L_S_STD;

  always_comb begin
    clear_od = 1'b0;
    if (low_us >= L_RST) begin
      cls      = CL_RESET;
      clear_od = 1'b1;
    end else if (od && (low_us >= L_OD_MIN) && (low_us <= L_OD_MAX)) begin
      cls = CL_RESET;
    end else if (od && (low_us > L_OD_MAX)) begin
      cls = CL_NONE;
    end else if (low_us < sample_lim) begin
      cls = CL_BIT1;
    end else begin
      cls = CL_BIT0;
    end
  end

endmodule

// File: rtl/sw_slot_fsm.sv
module sw_slot_fsm
  import sw_phy_pkg::*;
#(
  parameter int RST_STD_US    = 480,
  parameter int RST_OD_MIN_US = 60,
  parameter int RST_OD_MAX_US = 80,
  parameter int SAMPLE_STD_US = 30,
  parameter int SAMPLE_OD_US  = 3,
  parameter int READ0_STD_US  = 30,
  parameter int READ0_OD_US   = 3,
  parameter int PDH_STD_US    = 30,
  parameter int PDH_OD_US     = 3,
  parameter int PDL_STD_US    = 120,
  parameter int PDL_OD_US     = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_s,
  input  logic rise,
  input  logic holdoff_busy,
  input  logic od_enter,
  input  logic tx_valid,
  input  logic tx_bit,
  output logic pull_low,
  output logic rx_valid,
  output logic rx_bit,
  output logic reset_pulse,
  output logic od_active,
  output logic tx_ack,
  output logic slot_start,
  output logic release_evt
);

  localparam int CNT_W = $clog2(RST_STD_US + 1);
  localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(RST_STD_US);
  localparam logic [CNT_W-1:0] PDH_S_END = CNT_W'(PDH_STD_US - 1);
  localparam logic [CNT_W-1:0] PDH_O_END = CNT_W'(PDH_OD_US - 1);
  localparam logic [CNT_W-1:0] PDL_S_END = CNT_W'(PDL_STD_US - 1);
  localparam logic [CNT_W-1:0] PDL_O_END = CNT_W'(PDL_OD_US - 1);
  localparam logic [CNT_W-1:0] RD0_S     = CNT_W'(READ0_STD_US);
  localparam logic [CNT_W-1:0] RD0_O     = CNT_W'(READ0_OD_US);

  slot_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             is_read_q, is_read_d;
  logic             txb_q, txb_d;
  logic             od_q, od_d;
  logic             rxv_q, rxv_d;
  logic             rxb_q, rxb_d;
  logic             rstp_q, rstp_d;
  logic             ack_q, ack_d;

  low_class_e       cls;
  logic             clear_od;
  logic [CNT_W-1:0] pdh_end, pdl_end, rd0_lim;

  sw_low_classify #(
    .CNT_W        (CNT_W),
    .RST_STD_US   (RST_STD_US),
    .RST_OD_MIN_US(RST_OD_MIN_US),
    .RST_OD_MAX_US(RST_OD_MAX_US),
    .SAMPLE_STD_US(SAMPLE_STD_US),
    .SAMPLE_OD_US (SAMPLE_OD_US)
  ) i_classify (
    .low_us  (cnt_q),
    .od      (od_q),
    .cls     (cls),
    .clear_od(clear_od)
  );

  assign pdh_end = od_q ? PDH_O_END : PDH_S_END;
  assign pdl_end = od_q ? PDL_O_END : PDL_S_END;
  assign rd0_lim = od_q ? RD0_O : RD0_S;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    is_read_d   = is_read_q;
    txb_d       = txb_q;
    od_d        = od_q;
    rxv_d       = 1'b0;
    rxb_d       = rxb_q;
    rstp_d      = 1'b0;
    ack_d       = 1'b0;
    slot_start  = 1'b0;
    release_evt = 1'b0;
    case (state_q)
      ST_IDLE: begin
        // level start: a low that outlives the hold-off still opens a slot
        if (!line_s && !holdoff_busy) begin
          state_d    = ST_LOW;
          cnt_d      = '0;
          slot_start = 1'b1;
          is_read_d  = tx_valid;
          txb_d      = tx_bit;
          ack_d      = tx_valid;
        end
      end
      ST_LOW: begin
        if (rise) begin
          cnt_d   = '0;
          state_d = ST_IDLE;
          case (cls)
            CL_RESET: begin
              rstp_d  = 1'b1;
              state_d = ST_PDH;
              if (clear_od) od_d = 1'b0;
            end
            CL_BIT0, CL_BIT1: begin
              if (!is_read_q) begin
                rxv_d = 1'b1;
                rxb_d = (cls == CL_BIT1);
              end
            end
            default: ;
          endcase
        end else if (tick && (cnt_q != CNT_SAT)) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PDH: begin
        if (tick) begin
          if (cnt_q == pdh_end) begin
            state_d = ST_PDL;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_PDL: begin
        if (tick) begin
          if (cnt_q == pdl_end) begin
            state_d     = ST_IDLE;
            cnt_d       = '0;
            release_evt = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (od_enter) od_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      is_read_q <= 1'b0;
      txb_q     <= 1'b1;
      od_q      <= 1'b0;
      rxv_q     <= 1'b0;
      rxb_q     <= 1'b0;
      rstp_q    <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      is_read_q <= is_read_d;
      txb_q     <= txb_d;
      od_q      <= od_d;
      rxv_q     <= rxv_d;
      rxb_q     <= rxb_d;
      rstp_q    <= rstp_d;
      ack_q     <= ack_d;
    end
  end

  assign pull_low    = (state_q == ST_PDL) |
                       ((state_q == ST_LOW) & is_read_q & ~txb_q & (cnt_q < rd0_lim));
  assign rx_valid    = rxv_q;
  assign rx_bit      = rxb_q;
  assign reset_pulse = rstp_q;
  assign od_active   = od_q;
  assign tx_ack      = ack_q;

endmodule

// File: rtl/sw_slave_phy.sv
module sw_slave_phy #(
  parameter int SYNC_STAGES   = 2,
  parameter int HOLDOFF_US    = 4,
  parameter int RST_STD_US    = 480,
  parameter int RST_OD_MIN_US = 60,
  parameter int RST_OD_MAX_US = 80,
  parameter int SAMPLE_STD_US = 30,
  parameter int SAMPLE_OD_US  = 3,
  parameter int READ0_STD_US  = 30,
  parameter int READ0_OD_US   = 3,
  parameter int PDH_STD_US    = 30,
  parameter int PDH_OD_US     = 3,
  parameter int PDL_STD_US    = 120,
  parameter int PDL_OD_US     = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic line_in,
  input  logic od_enter,
  input  logic tx_valid,
  input  logic tx_bit,
  output logic pull_low_out,
  output logic reset_detected,
  output logic rx_valid,
  output logic rx_bit,
  output logic tx_ack,
  output logic od_active
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       line_s, rise;
  logic       holdoff_busy, holdoff_load;
  logic       slot_start, release_evt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sw_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .line_in(line_in),
    .line_s (line_s),
    .rise   (rise)
  );

  // own release after presence also opens the window, since the
  // synchronized line still shows our pull for a few cycles
  assign holdoff_load = rise | release_evt;

  sw_holdoff #(.HOLDOFF_US(HOLDOFF_US)) i_holdoff (
    .clk  (clk),
    .rst_n(rst_int_n),
    .tick (tick_us),
    .load (holdoff_load),
    .busy (holdoff_busy)
  );

  sw_slot_fsm #(
    .RST_STD_US   (RST_STD_US),
    .RST_OD_MIN_US(RST_OD_MIN_US),
    .RST_OD_MAX_US(RST_OD_MAX_US),
    .SAMPLE_STD_US(SAMPLE_STD_US),
    .SAMPLE_OD_US (SAMPLE_OD_US),
    .READ0_STD_US (READ0_STD_US),
    .READ0_OD_US  (READ0_OD_US),
    .PDH_STD_US   (PDH_STD_US),
    .PDH_OD_US    (PDH_OD_US),
    .PDL_STD_US   (PDL_STD_US),
    .PDL_OD_US    (PDL_OD_US)
  ) i_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .tick        (tick_us),
    .line_s      (line_s),
    .rise        (rise),
    .holdoff_busy(holdoff_busy),
    .od_enter    (od_enter),
    .tx_valid    (tx_valid),
    .tx_bit      (tx_bit),
    .pull_low    (pull_low_out),
    .rx_valid    (rx_valid),
    .rx_bit      (rx_bit),
    .reset_pulse (reset_detected),
    .od_active   (od_active),
    .tx_ack      (tx_ack),
    .slot_start  (slot_start),
    .release_evt (release_evt)
  );

endmodule

// File: rtl/sw_slave_phy_chk.sv
module sw_slave_phy_chk (
  input logic clk,
  input logic rst_n,
  input logic od_enter,
  input logic pull_low_out,
  input logic reset_detected,
  input logic rx_valid,
  input logic tx_ack,
  input logic od_active,
  input logic slot_start,
  input logic holdoff_busy
);

  // R2: a bit and a reset never end the same slot
  p_rx_or_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && reset_detected));

  // R4: reset indication is a single-cycle pulse
  p_reset_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reset_detected |=> !reset_detected);

  // R4: speed only drops back together with a reset indication
  p_od_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(od_active) |-> reset_detected);

  // R7: presence is not driven while the reset is being reported
  p_no_pull_at_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_detected |-> !pull_low_out);

  // R9: acknowledge of a pending bit is a single-cycle pulse
  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack |=> !tx_ack);

  // R10: no slot opens while the hold-off window runs
  p_no_start_in_holdoff_r10: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |-> !holdoff_busy);

  // R11: entering overdrive takes effect on the next cycle
  p_od_enter_r11: assert property (@(posedge clk) disable iff (!rst_n)
    od_enter |=> od_active);

endmodule

bind sw_slave_phy sw_slave_phy_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .od_enter      (od_enter),
  .pull_low_out  (pull_low_out),
  .reset_detected(reset_detected),
  .rx_valid      (rx_valid),
  .tx_ack        (tx_ack),
  .od_active     (od_active),
  .slot_start    (slot_start),
  .holdoff_busy  (holdoff_busy)
);

// File: tb/test_sw_slave_phy.sv
module test_sw_slave_phy;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;   // clocks per microsecond tick

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b0;
  logic m_low = 1'b0;
  logic od_enter = 1'b0;
  logic tx_valid = 1'b0;
  logic tx_bit = 1'b1;
  wire  line_in;
  logic pull_low_out, reset_detected, rx_valid, rx_bit, tx_ack, od_active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit cur_od = 1'b0;
  int rx_count = 0;
  int rst_count = 0;
  int ack_count = 0;
  logic rx_last = 1'b0;
  int tick_div = 0;

  assign line_in = ~(m_low | pull_low_out);

  sw_slave_phy i_sw_slave_phy (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_us       (tick_us),
    .line_in       (line_in),
    .od_enter      (od_enter),
    .tx_valid      (tx_valid),
    .tx_bit        (tx_bit),
    .pull_low_out  (pull_low_out),
    .reset_detected(reset_detected),
    .rx_valid      (rx_valid),
    .rx_bit        (rx_bit),
    .tx_ack        (tx_ack),
    .od_active     (od_active)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tick_div = (tick_div + 1) % TICK_DIV;
    tick_us  = (tick_div == 0);
  end

  always @(posedge clk) begin
    if (rx_valid) begin
      rx_count = rx_count + 1;
      rx_last  = rx_bit;
    end
    if (reset_detected) rst_count = rst_count + 1;
    if (tx_ack) ack_count = ack_count + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // 0 = bit 0, 1 = bit 1, 2 = reset, 3 = nothing
  function automatic int exp_class(input int low_us, input bit od);
    if (low_us >= 480) return 2;
    if (od && low_us >= 60 && low_us <= 80) return 2;
    if (od && low_us > 80) return 3;
    if (low_us < (od ? 3 : 30)) return 1;
    return 0;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure_presence(input bit od, input string tag);
    int c1, c2;
    c1 = 0;
    c2 = 0;
    while (!pull_low_out && c1 < 4000) begin
      @(negedge clk);
      c1++;
    end
    while (pull_low_out && c2 < 4000) begin
      @(negedge clk);
      c2++;
    end
    if (od) begin
      check(c1 >= 8 && c1 <= 20, {tag, " R8 presence wait"}, c1, 3*TICK_DIV);
      check(c2 >= 44 && c2 <= 52, {tag, " R8 presence low"}, c2, 12*TICK_DIV);
    end else begin
      check(c1 >= 112 && c1 <= 128, {tag, " R7 presence wait"}, c1, 30*TICK_DIV);
      check(c2 >= 472 && c2 <= 484, {tag, " R7 presence low"}, c2, 120*TICK_DIV);
    end
  endtask

  // master holds the line low for 'us' microseconds, result checked
  task automatic low_slot(input int us, input string tag);
    int rx0, rs0, cls;
    rx0 = rx_count;
    rs0 = rst_count;
    cls = exp_class(us, cur_od);
    @(negedge clk);
    m_low = 1'b1;
    wait_clk(us*TICK_DIV);
    m_low = 1'b0;
    if (cls == 2) begin
      if (us >= 480) cur_od = 1'b0;
      measure_presence(cur_od, tag);
      check(rst_count - rs0 == 1, {tag, " reset count"}, rst_count - rs0, 1);
      check(rx_count == rx0, {tag, " no bit on reset"}, rx_count - rx0, 0);
      check(od_active == cur_od, {tag, " speed after reset"}, od_active, cur_od);
      wait_clk(10*TICK_DIV);
    end else begin
      wait_clk(cur_od ? 8*TICK_DIV : 20*TICK_DIV);
      if (cls == 3) begin
        check(rx_count == rx0 && rst_count == rs0, {tag, " ignored"},
              (rx_count - rx0) + (rst_count - rs0), 0);
      end else begin
        check(rx_count - rx0 == 1, {tag, " bit count"}, rx_count - rx0, 1);
        check(rx_last == cls[0], {tag, " bit value"}, rx_last, cls);
        check(rst_count == rs0, {tag, " no reset"}, rst_count - rs0, 0);
      end
    end
  endtask

  task automatic read_slot(input bit b, input string tag);
    int rx0, ak0;
    rx0 = rx_count;
    ak0 = ack_count;
    tx_bit   = b;
    tx_valid = 1'b1;
    @(negedge clk);
    m_low = 1'b1;
    wait_clk(cur_od ? TICK_DIV : 5*TICK_DIV);
    m_low = 1'b0;
    wait_clk(cur_od ? 3 : 10*TICK_DIV);
    check(line_in == b, {tag, " R9 line at sample"}, line_in, b);
    tx_valid = 1'b0;
    wait_clk(cur_od ? 8*TICK_DIV : 40*TICK_DIV);
    check(line_in == 1'b1, {tag, " R9 line released"}, line_in, 1);
    check(ack_count - ak0 == 1, {tag, " R9 ack"}, ack_count - ak0, 1);
    check(rx_count == rx0, {tag, " R9 no rx"}, rx_count - rx0, 0);
  endtask

  initial begin
    int seed_val;
    int rx0, rs0, kind, us;
    seed_val = $urandom(32'd20240611);
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(10);

    // R1 reset state
    check(pull_low_out == 1'b0, "R1 pull idle", pull_low_out, 0);
    check(od_active == 1'b0, "R1 standard speed", od_active, 0);
    check(rx_count == 0 && rst_count == 0, "R1 no pulses", rx_count + rst_count, 0);

    // R4 / R7 long reset at standard speed
    low_slot(500, "R4 std reset");

    // R2 standard writes
    low_slot(8, "R2 write1");
    low_slot(70, "R2 write0");
    low_slot(300, "R2 long write0");
    low_slot(14, "R2 write1 late");

    // R9 standard reads
    read_slot(1'b0, "R9 std read0");
    read_slot(1'b1, "R9 std read1");

    // R10 glitch inside hold-off is ignored
    rx0 = rx_count;
    rs0 = rst_count;
    @(negedge clk);
    m_low = 1'b1;
    wait_clk(8*TICK_DIV);
    m_low = 1'b0;
    wait_clk(4);
    m_low = 1'b1;
    wait_clk(3);
    m_low = 1'b0;
    wait_clk(30*TICK_DIV);
    check(rx_count - rx0 == 1, "R10 glitch in hold-off ignored", rx_count - rx0, 1);
    check(rx_last == 1'b1, "R10 first slot bit", rx_last, 1);
    check(rst_count == rs0, "R10 no reset", rst_count - rs0, 0);

    // R10 deep droop beyond the window opens a slot
    rx0 = rx_count;
    @(negedge clk);
    m_low = 1'b1;
    wait_clk(8*TICK_DIV);
    m_low = 1'b0;
    wait_clk(4);
    m_low = 1'b1;
    wait_clk(70*TICK_DIV);
    m_low = 1'b0;
    wait_clk(30*TICK_DIV);
    check(rx_count - rx0 == 2, "R10 droop opens slot", rx_count - rx0, 2);
    check(rx_last == 1'b0, "R10 droop decoded as 0", rx_last, 0);

    // R10 the same short glitch after the window is a slot
    rx0 = rx_count;
    @(negedge clk);
    m_low = 1'b1;
    wait_clk(3);
    m_low = 1'b0;
    wait_clk(20*TICK_DIV);
    check(rx_count - rx0 == 1 && rx_last == 1'b1, "R10 glitch after window",
          rx_count - rx0, 1);

    // random standard-speed traffic (R2, R9)
    for (int i = 0; i < 16; i++) begin
      kind = $urandom_range(0, 3);
      if (kind == 0) begin
        read_slot(1'($urandom_range(0, 1)), "R9 rand std");
      end else begin
        if (kind == 1) us = $urandom_range(6, 14);
        else           us = $urandom_range(40, 300);
        low_slot(us, "R2 rand std");
      end
    end

    // R11 enter overdrive
    @(negedge clk);
    od_enter = 1'b1;
    @(negedge clk);
    od_enter = 1'b0;
    cur_od = 1'b1;
    wait_clk(2);
    check(od_active == 1'b1, "R11 overdrive on", od_active, 1);

    // R3 overdrive writes, R9 overdrive reads
    low_slot(1, "R3 od write1");
    low_slot(10, "R3 od write0");
    low_slot(5, "R3 od write0 short");
    read_slot(1'b0, "R9 od read0");
    read_slot(1'b1, "R9 od read1");

    // R5 / R8 short reset keeps overdrive
    low_slot(70, "R5 od reset");
    // R6 mid-length low ignored in overdrive
    low_slot(200, "R6 od ignored");
    low_slot(1, "R3 od after ignore");

    // random overdrive traffic (R3, R5, R6, R9)
    for (int i = 0; i < 20; i++) begin
      kind = $urandom_range(0, 4);
      if (kind == 0) begin
        read_slot(1'($urandom_range(0, 1)), "R9 rand od");
      end else begin
        case (kind)
          1:       us = 1;
          2:       us = $urandom_range(5, 50);
          3:       us = $urandom_range(63, 77);
          default: us = $urandom_range(90, 300);
        endcase
        low_slot(us, "R3 R5 R6 rand od");
      end
    end

    // R4 long reset leaves overdrive, R7 standard presence
    low_slot(500, "R4 od long reset");
    low_slot(8, "R2 std after exit");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule